// File: doc/BRIEF.md
# Circular Descriptor Chain Walker

This block runs a DMA channel through a chain of transfer descriptors held in memory. Software writes descriptors into a memory region and links them in a ring. Each descriptor ends with a pointer to the next one, and the last pointer leads back to the first. A single start strobe with the head address sets the walk going. The walker reads one descriptor word by word over a simple request/valid read port. It then presents the whole configuration to the channel with a one-cycle load strobe and waits for the channel to report that the transaction is done. After that it follows the stored pointer to the next descriptor.

The ring has no null terminator, so the walker keeps the head address and ends the walk when a next pointer leads back to it. At that point it raises a list-done pulse that is separate from the channel's own per-transaction done. Because it stops there, a stale descriptor is never reloaded. A read address that is not word aligned stops the walk and sets an error flag. A start that arrives during a walk is dropped and recorded in a reject flag. The data mover itself sits outside this block.

Top module: `ll_desc_walker`

## Requirements
- R1: After reset the walker is idle: busy, mem_req, cfg_load and list_done are low, and walk_err and busy_rej are 0.
- R2: An accepted start captures head_ptr. The walker reads NW words of a descriptor at ascending addresses base, base+DW/8, and so on. Only one read is outstanding at a time, and mem_req with its mem_addr is held until mem_rvalid arrives.
- R3: cfg_load is a one-cycle pulse given only after all NW words of a descriptor have arrived. cfg_data carries words 0 to NW-2, with word k at bits [k*DW +: DW]. cfg_data changes only in the cycle after an accepted read word.
- R4: After cfg_load the walker waits for chan_done and issues no read. A chan_done while the walker is idle has no effect.
- R5: If the last descriptor word (the next pointer) differs from the captured head, the walker fetches the next descriptor from that pointer once chan_done arrives.
- R6: If the next pointer equals the captured head, chan_done ends the walk: list_done pulses for one cycle, busy drops, and no further load is issued.
- R7: A read address whose low log2(DW/8) bits are not zero is never requested. The walk stops, walk_err is set, and list_done is not raised.
- R8: A start while busy is ignored: the running walk continues unchanged and busy_rej is set.
- R9: walk_err and busy_rej stay set until the next accepted start, which clears them.
- R10: busy is high from the cycle after an accepted start until the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe |
| head_ptr | input | AW | Address of the first descriptor |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Read request, held until valid |
| mem_addr | output | AW | Read address |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | DW | Read data |
| cfg_load | output | 1 | Configuration load strobe |
| cfg_data | output | (NW-1)*DW | Parallel configuration words |
| chan_done | input | 1 | Channel transaction done |
| list_done | output | 1 | Whole chain finished |
| walk_err | output | 1 | Misaligned address aborted the walk |
| busy_rej | output | 1 | Start was dropped while busy |

## Verification
The bench builds the walker with AW=16, DW=32 and NW=6. A 64-word memory model answers each read two cycles after the request. With these values several descriptors fit at distinct bases, so the tests can cover three-node rings, a node that points to itself, and a pointer that is misaligned by two bytes. A channel model counts the words delivered before each load strobe and answers with chan_done a few cycles after each load. This brings partial loads, walk ends at the head, and starts dropped during a walk into the checks.

// File: rtl/ll_desc_walker.sv
module ll_desc_walker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        head_ptr,
  output logic                 busy,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 cfg_load,
  output logic [(NW-1)*DW-1:0] cfg_data,
  input  logic                 chan_done,
  output logic                 list_done,
  output logic                 walk_err,
  output logic                 busy_rej
);
  localparam int BYTES = DW / 8;
  localparam int AL    = $clog2(BYTES);
  localparam int IW    = $clog2(NW);
  localparam int CW    = (NW - 1) * DW;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOAD, S_WAIT} st_t;

  st_t           st;
  logic [AW-1:0] head_q, cur_q, nxt_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cfg_q;
  logic          done_q, err_q, rej_q;
  logic          misal, take, last;

  assign misal     = |mem_addr[AL-1:0];
  assign mem_addr  = cur_q + (AW'(idx_q) << AL);
  assign mem_req   = (st == S_FETCH) && !misal;
  assign take      = mem_req && mem_rvalid;
  assign last      = idx_q == IW'(NW - 1);
  assign busy      = st != S_IDLE;
  assign cfg_load  = st == S_LOAD;
  assign cfg_data  = cfg_q;
  assign list_done = done_q;
  assign walk_err  = err_q;
  assign busy_rej  = rej_q;

  for (genvar w = 0; w < NW - 1; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[w*DW +: DW] <= '0;
      else if (take && idx_q == IW'(w))
        cfg_q[w*DW +: DW] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      head_q <= '0;
      cur_q  <= '0;
      nxt_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy && start) rej_q <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          head_q <= head_ptr;
          cur_q  <= head_ptr;
          idx_q  <= '0;
          err_q  <= 1'b0;
          rej_q  <= 1'b0;
          st     <= S_FETCH;
        end
        S_FETCH: begin
          if (misal) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (mem_rvalid) begin
            if (last) begin
              nxt_q <= mem_rdata[AW-1:0];
              st    <= S_LOAD;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        S_LOAD: st <= S_WAIT;
        S_WAIT: if (chan_done) begin
          if (nxt_q == head_q) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cur_q <= nxt_q;
            idx_q <= '0;
            st    <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_desc_walker_chk.sv
module ll_desc_walker_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NW = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 mem_req,
  input logic [AW-1:0]        mem_addr,
  input logic                 mem_rvalid,
  input logic                 cfg_load,
  input logic [(NW-1)*DW-1:0] cfg_data,
  input logic                 list_done,
  input logic                 walk_err,
  input logic                 busy_rej
);
  localparam int AL = $clog2(DW / 8);

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[AL-1:0] == '0)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R2
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !cfg_load); // R3
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rvalid |=> $stable(cfg_data)); // R3
  AST_NO_READ_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !mem_req); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> (!busy && !cfg_load)); // R6
  AST_REJ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> busy_rej); // R8
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_err && !(start && !busy)) |=> walk_err); // R9
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R10
endmodule

bind ll_desc_walker ll_desc_walker_chk #(.AW(AW), .DW(DW), .NW(NW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .cfg_load(cfg_load),
  .cfg_data(cfg_data), .list_done(list_done), .walk_err(walk_err),
  .busy_rej(busy_rej)
);

// File: tb/ll_desc_walker_tb_top.sv
`timescale 1ns/1ps
module ll_desc_walker_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NW = 6;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] head_ptr = '0;
  logic busy, mem_req, cfg_load, list_done, walk_err, busy_rej;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [(NW-1)*DW-1:0] cfg_data;
  logic chan_done = 1'b0;

  always #2 clk = ~clk;

  ll_desc_walker #(.AW(AW), .DW(DW), .NW(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .cfg_load(cfg_load), .cfg_data(cfg_data),
    .chan_done(chan_done), .list_done(list_done), .walk_err(walk_err),
    .busy_rej(busy_rej)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [64];
  logic [(NW-1)*DW-1:0] cap [8];
  int loads = 0, ld_cnt = 0, words = 0, partial = 0, reqs = 0;
  bit auto_done = 1'b1;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder and channel model
  initial begin
    int cnt = 0, pend = 0;
    forever begin
      @(negedge clk);
      if (cfg_load) begin
        if (loads < 8) cap[loads] = cfg_data;
        loads++;
        if (words != NW) partial++;
        words = 0;
      end
      if (list_done) ld_cnt++;
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        if (cnt == LAT) begin
          mem_rvalid = 1'b1;
          mem_rdata = mem[mem_addr[7:2]];
          words++;
          reqs++;
          cnt = 0;
        end else cnt++;
      end
      chan_done = 1'b0;
      if (pend != 0) begin
        pend--;
        if (pend == 0) chan_done = 1'b1;
      end
      if (cfg_load && auto_done) pend = 3;
    end
  end

  task automatic set_node(input int base, input logic [DW-1:0] nxt);
    for (int i = 0; i < NW - 1; i++) mem[base/4 + i] = 32'hC0DE_0000 | 32'(base + i);
    mem[base/4 + NW - 1] = nxt;
  endtask

  task automatic clear_log();
    loads = 0; ld_cnt = 0; words = 0; partial = 0; reqs = 0;
  endtask

  task automatic pulse_start(input logic [AW-1:0] h);
    head_ptr = h;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_cap(input int k, input int base, input string tag);
    logic [(NW-1)*DW-1:0] e;
    for (int i = 0; i < NW - 1; i++) e[i*DW +: DW] = mem[base/4 + i];
    chk(cap[k] == e, tag, cap[k][DW-1:0], e[DW-1:0]);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req && !cfg_load && !list_done, "R1 outputs idle", busy, 0);
    chk(!walk_err && !busy_rej, "R1 flags clear", {walk_err, busy_rej}, 0);
  endtask

  task automatic t_three_ring();
    set_node(16'h00, 32'h40); set_node(16'h40, 32'h80); set_node(16'h80, 32'h00);
    clear_log();
    pulse_start(16'h00);
    chk(busy, "R10 busy after start", busy, 1);
    wait_idle();
    chk(loads == 3, "R5 three loads", loads, 3);
    chk(reqs == 3*NW, "R2 word reads", reqs, 3*NW);
    chk(partial == 0, "R3 full descriptor before load", partial, 0);
    chk_cap(0, 16'h00, "R2 first config");
    chk_cap(1, 16'h40, "R5 second config");
    chk_cap(2, 16'h80, "R5 third config");
    chk(ld_cnt == 1, "R6 one list done", ld_cnt, 1);
    chk(!busy && !walk_err, "R6 idle no error", {busy, walk_err}, 0);
  endtask

  task automatic t_self_loop();
    set_node(16'hC0, 32'hC0);
    clear_log();
    pulse_start(16'hC0);
    wait_idle();
    chk(loads == 1, "R6 self ring single load", loads, 1);
    chk(ld_cnt == 1, "R6 self ring list done", ld_cnt, 1);
    chk_cap(0, 16'hC0, "R3 self ring config");
  endtask

  task automatic t_busy_reject();
    set_node(16'h00, 32'h40); set_node(16'h40, 32'h80); set_node(16'h80, 32'h00);
    clear_log();
    pulse_start(16'h00);
    repeat (4) @(negedge clk);
    pulse_start(16'hC0);
    chk(busy_rej, "R8 reject flag", busy_rej, 1);
    wait_idle();
    chk(loads == 3, "R8 walk unchanged loads", loads, 3);
    chk_cap(0, 16'h00, "R8 original head kept");
    chk(busy_rej, "R9 reject flag held", busy_rej, 1);
    set_node(16'hC0, 32'hC0);
    pulse_start(16'hC0);
    chk(!busy_rej, "R9 reject cleared on start", busy_rej, 0);
    wait_idle();
  endtask

  task automatic t_misaligned_head();
    clear_log();
    pulse_start(16'h02);
    wait_idle();
    chk(walk_err, "R7 error on misaligned head", walk_err, 1);
    chk(reqs == 0 && loads == 0, "R7 no read no load", reqs + loads, 0);
    chk(ld_cnt == 0, "R7 no list done", ld_cnt, 0);
  endtask

  task automatic t_misaligned_next();
    set_node(16'h00, 32'h46);
    clear_log();
    pulse_start(16'h00);
    chk(!walk_err, "R9 error cleared on start", walk_err, 0);
    wait_idle();
    chk(loads == 1, "R7 one load before bad pointer", loads, 1);
    chk(walk_err && ld_cnt == 0, "R7 abort without list done", {walk_err, 8'(ld_cnt)}, 9'h100);
  endtask

  task automatic t_stray_done();
    clear_log();
    auto_done = 1'b0;
    @(negedge clk);
    force chan_done = 1'b1;
    @(negedge clk);
    release chan_done;
    repeat (2) @(negedge clk);
    chk(!busy && ld_cnt == 0 && loads == 0, "R4 idle done ignored", busy, 0);
    set_node(16'hC0, 32'hC0);
    pulse_start(16'hC0);
    repeat (60) @(negedge clk);
    chk(busy && loads == 1, "R4 waits for done", {busy, 8'(loads)}, 9'h101);
    chk(reqs == NW, "R4 no read while waiting", reqs, NW);
    force chan_done = 1'b1;
    @(negedge clk);
    release chan_done;
    auto_done = 1'b1;
    wait_idle();
    chk(ld_cnt == 1, "R6 done ends walk", ld_cnt, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_three_ring();
    t_self_loop();
    t_busy_reject();
    t_misaligned_head();
    t_misaligned_next();
    t_stray_done();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule